// File: doc/BRIEF.md
# Serial Bootstrap RAM Loader

This block stands in for a boot ROM. After reset it reads a mode strap. If the strap asks for serial boot, the block keeps the host CPU off the memory bus with its bus tri-stated. It takes a fixed-length code image from an asynchronous serial line and writes each received byte into RAM, starting at address zero and counting upward. Once the final byte is stored, it releases the CPU, which then starts executing the loaded image at address zero.

If the strap asks for normal boot, the block releases the CPU on the first cycle after reset and does not touch RAM. The serial receiver is built into the block. It samples the line at sixteen times the bit rate, confirms a start bit at mid-bit, and drops any frame whose stop bit is low.

Top module: `serial_boot_loader`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cpu_hold` is 1, `ram_we` is 0 and `ram_addr` is 0.
- R2: `boot_serial` is sampled only in the first cycle after reset. A value of 1 keeps `cpu_hold` at 1 for loading. A value of 0 drops `cpu_hold` to 0 one clock later, and no RAM write ever follows. Changes to the strap after that cycle have no effect.
- R3: The n-th accepted frame (counting from 0) is written at `ram_addr` = n. This gives ascending addresses starting at 0, with exactly one write per accepted frame.
- R4: Frames are 8N1, with the least significant bit sent first and an idle-high line. Each bit lasts `CLK_PER_BIT` clocks (192 by default). The byte written equals the byte sent.
- R5: Each write is a `ram_we` pulse exactly one cycle long, with `ram_addr` and `ram_wdata` valid during that cycle. `ram_addr` increases by 1 in the following cycle.
- R6: `cpu_hold` falls one cycle after the write strobe of byte number `IMAGE_LEN` (255 by default, at address 254). It stays at 0 until reset.
- R7: A frame whose stop bit samples low causes no write and leaves `ram_addr` unchanged.
- R8: A low pulse on `rx_in` that is shorter than half a bit time does not start a frame and causes no write.
- R9: A reset during loading returns the block to idle with the count cleared, so the next accepted frame is written at address 0.
- R10: `ram_we` is never 1 while `cpu_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bit time is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| boot_serial | input | 1 | Mode strap: 1 selects serial loading, 0 selects normal boot |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | One-cycle RAM write strobe |
| cpu_hold | output | 1 | 1 keeps the CPU halted with its bus tri-stated |

## Verification
- **Write strobe:** after a good frame, the strobe appears a few clocks after the mid-stop sample. That delay comes from the two-flop synchroniser, the oversample tick and the controller register. The address then steps one cycle after the strobe, and on the final byte `cpu_hold` falls in that same following cycle.
- **Write capture:** a falling-edge monitor records the cycle number, address and data of every strobe.
- **Per-frame checks:** each frame check runs only after the whole stop bit has been driven, by which time the write is due.
- **Cycle-exact timing:** the one-cycle strobe, the address step and the release timing are checked by comparing the recorded cycle numbers, not by polling.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_WAIT,
    LD_WRITE,
    LD_RUN
  } load_state_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

endpackage

// File: rtl/sb_tick_gen.sv
module sb_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // Ticks are spaced at least two clocks apart when DIV >= 2
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && DIV > 1) |=> !tick);  // R4

endmodule

// File: rtl/sb_uart_rx.sv
module sb_uart_rx #(
  parameter int CLK_PER_BIT = 192,
  parameter int OVS         = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_in,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  import sb_pkg::*;

  localparam int DIV = CLK_PER_BIT / OVS;
  localparam int SCW = $clog2(OVS);
  localparam logic [SCW-1:0] HALF = SCW'(OVS / 2 - 1);
  localparam logic [SCW-1:0] FULL = SCW'(OVS - 1);

  logic [1:0]     sync;
  logic           rx_s;
  logic           tick;
  logic           tick_clr;
  rx_state_t      state;
  logic [SCW-1:0] scnt;
  logic [2:0]     bitn;
  logic [7:0]     shreg;

  assign rx_s     = sync[1];
  assign tick_clr = (state == RX_IDLE) && !rx_s;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rx_in};
  end

  sb_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (tick_clr),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      scnt       <= '0;
      bitn       <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          scnt <= '0;
          bitn <= '0;
          if (!rx_s) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (scnt == HALF) begin
            scnt  <= '0;
            state <= rx_s ? RX_IDLE : RX_DATA;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (scnt == FULL) begin
            scnt  <= '0;
            shreg <= {rx_s, shreg[7:1]};
            if (bitn == 3'd7) state <= RX_STOP;
            bitn <= bitn + 1'b1;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (scnt == FULL) begin
            scnt  <= '0;
            state <= RX_IDLE;
            if (rx_s) begin
              byte_valid <= 1'b1;
              byte_data  <= shreg;
            end
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);  // R4
  AST_VALID_NEEDS_STOP: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> (state == RX_IDLE));  // R7

endmodule

// File: rtl/sb_load_ctrl.sv
module sb_load_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int IMAGE_LEN = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_serial,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_we,
  output logic              cpu_hold
);
  import sb_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMAGE_LEN - 1);

  load_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_IDLE;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_we    <= 1'b0;
      cpu_hold  <= 1'b1;
    end else begin
      case (state)
        LD_IDLE: begin
          state    <= boot_serial ? LD_WAIT : LD_RUN;
          cpu_hold <= boot_serial;
        end
        LD_WAIT: if (byte_valid) begin
          ram_wdata <= byte_data;
          ram_we    <= 1'b1;
          state     <= LD_WRITE;
        end
        LD_WRITE: begin
          ram_we   <= 1'b0;
          ram_addr <= ram_addr + 1'b1;
          if (ram_addr == LAST_ADDR) begin
            cpu_hold <= 1'b0;
            state    <= LD_RUN;
          end else begin
            state <= LD_WAIT;
          end
        end
        LD_RUN: begin
          ram_we   <= 1'b0;
          cpu_hold <= 1'b0;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);  // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));  // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ram_we |=> $stable(ram_addr));  // R7
  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |=> !cpu_hold);  // R6
  AST_NO_WRITE_FREE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> cpu_hold);  // R10
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr <= LAST_ADDR));  // R3

endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
  parameter int CLK_PER_BIT = 192,
  parameter int OVS         = 16,
  parameter int IMAGE_LEN   = 255,
  parameter int ADDR_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_serial,
  input  logic              rx_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_we,
  output logic              cpu_hold
);
  logic       byte_valid;
  logic [7:0] byte_data;

  sb_uart_rx #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .OVS         (OVS)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_in      (rx_in),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  sb_load_ctrl #(
    .ADDR_W    (ADDR_W),
    .IMAGE_LEN (IMAGE_LEN)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .boot_serial (boot_serial),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .ram_we      (ram_we),
    .cpu_hold    (cpu_hold)
  );

endmodule

// File: tb/serial_boot_loader_tb.sv
module serial_boot_loader_tb;
  localparam int CPB    = 32;
  localparam int LEN    = 255;
  localparam int ADDR_W = 16;

  localparam logic [7:0] PAT [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A,
                                     8'h01, 8'h80, 8'h3C, 8'hC3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boot_serial = 1'b1;
  logic rx_in = 1'b1;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic ram_we;
  logic cpu_hold;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  serial_boot_loader #(.CLK_PER_BIT(CPB), .OVS(16),
                       .IMAGE_LEN(LEN), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .boot_serial(boot_serial), .rx_in(rx_in),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .cpu_hold(cpu_hold));

  // Falling-edge monitor of the RAM port
  int cyc = 0, wr_cnt = 0, we_cyc = 0, fall_cyc = -1;
  int dbl_we = 0, step_err = 0, we_free = 0;
  logic [ADDR_W-1:0] last_addr = '0, prev_addr = '0;
  logic [7:0] last_data = '0;
  logic prev_we = 1'b0, prev_hold = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (ram_we) begin
        wr_cnt++;
        last_addr = ram_addr;
        last_data = ram_wdata;
        we_cyc = cyc;
        if (prev_we) dbl_we++;
        if (!cpu_hold) we_free++;
      end
      if (prev_we && ram_addr != prev_addr + 1'b1) step_err++;
      if (prev_hold && !cpu_hold) fall_cyc = cyc;
    end
    prev_we = ram_we;
    prev_addr = ram_addr;
    prev_hold = cpu_hold;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] img(input int i);
    return (i < 8) ? PAT[i] : 8'((i * 37 + 11) & 8'hFF);
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic stop_bit);
    rx_in = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      rx_in = d[b];
      repeat (CPB) @(negedge clk);
    end
    rx_in = stop_bit;
    repeat (CPB) @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic do_reset(input logic strap);
    boot_serial = strap;
    rst = 1'b1;
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
    check(cpu_hold === 1'b1 && ram_we === 1'b0 && ram_addr === '0,
          "R1 reset state", {ram_addr, 7'd0, cpu_hold}, 1);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    @(negedge clk);

    // Normal boot: strap low
    do_reset(1'b0);
    repeat (3) @(negedge clk);
    check(cpu_hold === 1'b0, "R2 strap low releases", cpu_hold, 0);
    send_frame(8'h55, 1'b1);
    repeat (CPB) @(negedge clk);
    check(wr_cnt == 0, "R2 R10 no write in normal boot", wr_cnt, 0);

    // Serial boot
    do_reset(1'b1);
    check(cpu_hold === 1'b1, "R2 strap high holds", cpu_hold, 1);

    // Short glitch
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    check(wr_cnt == 0, "R8 glitch ignored", wr_cnt, 0);

    // Bad stop bit
    send_frame(8'h96, 1'b0);
    repeat (2 * CPB) @(negedge clk);
    check(wr_cnt == 0 && ram_addr == 0, "R7 bad stop dropped", wr_cnt, 0);

    // Partial load, then reset
    send_frame(8'h11, 1'b1);
    send_frame(8'h22, 1'b1);
    check(wr_cnt == 2 && last_addr == 1 && last_data == 8'h22,
          "R3 partial load", last_addr, 1);
    do_reset(1'b1);
    check(ram_addr == 0 && cpu_hold === 1'b1, "R9 reset clears count", ram_addr, 0);

    // Full image; strap moved after sampling
    base = wr_cnt;
    boot_serial = 1'b0;
    for (int i = 0; i < LEN; i++) begin
      send_frame(img(i), 1'b1);
      if (i < 8 || i == LEN - 1 || (i % 50) == 0) begin
        check(wr_cnt == base + i + 1 && last_addr == ADDR_W'(i),
              "R3 address order", last_addr, i);
        check(last_data == img(i), "R4 byte value", last_data, img(i));
      end
      if (i == LEN - 2)
        check(cpu_hold === 1'b1, "R6 held before last", cpu_hold, 1);
    end
    check(cpu_hold === 1'b0, "R6 released after last", cpu_hold, 0);
    check(fall_cyc - we_cyc == 1, "R6 release timing", fall_cyc - we_cyc, 1);

    // After release: input has no effect
    base = wr_cnt;
    boot_serial = 1'b1;
    send_frame(8'h77, 1'b1);
    repeat (CPB) @(negedge clk);
    check(wr_cnt == base && cpu_hold === 1'b0, "R2 R10 no write after release",
          wr_cnt, base);

    check(dbl_we == 0, "R5 single-cycle strobe", dbl_we, 0);
    check(step_err == 0, "R5 address steps after strobe", step_err, 0);
    check(we_free == 0, "R10 no strobe while released", we_free, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule